// File: doc/BRIEF.md
# Four-Row 4x4 Box Averager

This block smooths one stream of 18-bit gradient products, such as the squared x gradient, the squared y gradient or their cross product. The products arrive in raster order with one value per accepted input, and each image row holds `ROW_LEN` values. For every position whose 4x4 neighbourhood is complete, the block emits the mean of the sixteen values in that neighbourhood. The neighbourhood ends at the current input, so it lies above and to the left of the newest sample. Because the window has sixteen entries, the division is a plain right shift by four.

Three earlier rows are held in a ring of four single-row memories, indexed by row number modulo four. Each accepted input reads the three stored rows at its own column in the same cycle. Those three values and the live sample together form one vertical four-value column, which moves into a four-deep shift window. Output is held back until four rows have arrived and four columns of the current row have entered the window. Each instance handles one product stream, so a corner detector needs three instances side by side.

Top module: `deriv_box_smoother`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0.
- R2: No result is produced for any input in row indices 0, 1 or 2, counted from reset.
- R3: From row index 3 on, an input at column index c yields a result only when c >= 3. The window restarts at column 0 of every row, so no window spans two rows.
- R4: For the input at row r and column c, the result equals floor(S/16). S is the sum of the sixteen inputs at rows r-3..r and columns c-3..c.
- R5: The result appears with `out_valid` high exactly two rising clock edges after the edge that samples the input, and `out_valid` stays high for one cycle.
- R6: Cycles with `in_valid` low store nothing and advance no counter, and the data on `in_data` in those cycles has no effect on any result.
- R7: Sixteen values of 2^18-1 average to exactly 2^18-1, so the internal sum never overflows.
- R8: The row memories are reused circularly. From row index 4 onward, results still use exactly the four most recent rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | DATA_W | Next gradient product in raster order |
| out_valid | output | 1 | One-cycle strobe marking a valid average |
| out_avg | output | DATA_W | Sum of the 4x4 window shifted right by four |

## Verification
On every cycle, the embedded assertions check several counter and window properties. The column counter wraps and the ring index advances only on the last column. Idle cycles freeze both counters. The completed-row count saturates. A row's first column always suppresses the next strobe, and a strobe is only possible with a full window one cycle after a column entered. The bench scenarios show everything else: the arithmetic value of each average, the exact two-edge latency, the silence during the first three rows and the first three columns of each row, the effect of garbage data during long idle gaps, full-scale sums, and correct results after the row ring has wrapped.

// File: rtl/box_avg_pkg.sv
// Shared constants for the 4x4 box averager.
// Assumes the window side is a power of two, so ring indices wrap naturally
// and the division by the window area is a right shift.
package box_avg_pkg;
    localparam int WIN      = 4;                 // window side in pixels
    localparam int WIN_LOG2 = $clog2(WIN);       // bits per ring index
    localparam int AREA_SHIFT = 2 * WIN_LOG2;    // log2 of window area
endpackage

// File: rtl/avg_row_store.sv
// Row ring for the box averager.
// Writes every accepted sample into one of WIN single-row memories, picked by
// row index modulo WIN. On the same accepted input it reads the other rows at
// that column, and one cycle later it presents a WIN-value column (oldest row
// first, live sample last). A column is only flagged once WIN-1 earlier rows
// are complete. Assumes a continuous raster stream with ROW_LEN values per row.
module avg_row_store
    import box_avg_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int ROW_LEN = 638
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    col_valid,
    output logic                    col_first,
    output logic [WIN*DATA_W-1:0]   col_data
);
    localparam int COL_W  = $clog2(ROW_LEN);
    localparam int BANK_W = WIN_LOG2;

    logic [COL_W-1:0]      wr_col;
    logic [BANK_W-1:0]     wr_bank;
    logic [BANK_W-1:0]     rows_seen;
    logic [BANK_W-1:0]     rd_base;
    logic [BANK_W-1:0]     slot;
    logic [DATA_W-1:0]     live_q;
    logic [WIN*DATA_W-1:0] bank_flat;
    logic                  last_col;

    assign last_col = (wr_col == COL_W'(ROW_LEN - 1));

    // Column, ring and completed-row counters; they move only on accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_col    <= '0;
            wr_bank   <= '0;
            rows_seen <= '0;
        end else if (in_valid) begin
            if (last_col) begin
                wr_col  <= '0;
                wr_bank <= wr_bank + BANK_W'(1);
                if (rows_seen != BANK_W'(WIN - 1))
                    rows_seen <= rows_seen + BANK_W'(1);
            end else begin
                wr_col <= wr_col + COL_W'(1);
            end
        end
    end

    // One memory per ring slot, written in turn and read at the live column.
    for (genvar b = 0; b < WIN; b++) begin : g_bank
        logic [DATA_W-1:0] mem [ROW_LEN];
        logic [DATA_W-1:0] rd_q;
        // Store the sample into this slot's row and fetch the stored value.
        always_ff @(posedge clk) begin
            if (in_valid && wr_bank == BANK_W'(b))
                mem[wr_col] <= in_data;
            if (in_valid)
                rd_q <= mem[wr_col];
        end
        assign bank_flat[b*DATA_W +: DATA_W] = rd_q;
    end

    // Column strobe, row-start flag, live sample and ring base for reordering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_valid <= 1'b0;
            col_first <= 1'b0;
            rd_base   <= '0;
            live_q    <= '0;
        end else begin
            col_valid <= in_valid && (rows_seen == BANK_W'(WIN - 1));
            if (in_valid) begin
                col_first <= (wr_col == '0);
                rd_base   <= wr_bank;
                live_q    <= in_data;
            end
        end
    end

    // Reorder the read ports so the oldest row lands in slot 0.
    always_comb begin
        slot = '0;
        for (int k = 0; k < WIN - 1; k++) begin
            slot = rd_base + BANK_W'(k + 1);
            col_data[k*DATA_W +: DATA_W] = bank_flat[int'(slot)*DATA_W +: DATA_W];
        end
        col_data[(WIN-1)*DATA_W +: DATA_W] = live_q;
    end

    // R3
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last_col) |=> (wr_col == '0 && wr_bank == BANK_W'($past(wr_bank) + BANK_W'(1))));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(wr_col) && $stable(wr_bank) && $stable(rows_seen)));
    // R2
    rows_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rows_seen == BANK_W'(WIN - 1)) |=> (rows_seen == BANK_W'(WIN - 1)));
endmodule

// File: rtl/avg_col_window.sv
// Sliding 4-wide window of columns.
// Each flagged column shifts into WIN shift registers (one per window row).
// The fill count restarts at a row's first column, so the window never mixes
// two rows; win_valid rises for one cycle each time the window holds WIN
// columns after a shift. Assumes col_data slot 0 is the oldest row.
module avg_col_window
    import box_avg_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        col_valid,
    input  logic                        col_first,
    input  logic [WIN*DATA_W-1:0]       col_data,
    output logic                        win_valid,
    output logic [WIN*WIN*DATA_W-1:0]   win_data
);
    localparam int FILL_W = $clog2(WIN + 1);

    logic [DATA_W-1:0] taps [WIN][WIN];
    logic [FILL_W-1:0] fill;

    // Shift each window row by one column on every flagged column.
    always_ff @(posedge clk) begin
        if (col_valid) begin
            for (int r = 0; r < WIN; r++) begin
                taps[r][0] <= col_data[r*DATA_W +: DATA_W];
                for (int a = 1; a < WIN; a++)
                    taps[r][a] <= taps[r][a-1];
            end
        end
    end

    // Track how many columns of the current row the window holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill      <= '0;
            win_valid <= 1'b0;
        end else begin
            win_valid <= 1'b0;
            if (col_valid) begin
                if (col_first) begin
                    fill      <= FILL_W'(1);
                    win_valid <= (WIN == 1);
                end else begin
                    if (fill != FILL_W'(WIN))
                        fill <= fill + FILL_W'(1);
                    win_valid <= (fill >= FILL_W'(WIN - 1));
                end
            end
        end
    end

    // Flatten the window for the adder.
    always_comb begin
        for (int r = 0; r < WIN; r++)
            for (int a = 0; a < WIN; a++)
                win_data[(r*WIN + a)*DATA_W +: DATA_W] = taps[r][a];
    end

    // R3
    row_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_first) |=> !win_valid);
    // R4
    full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (fill == FILL_W'(WIN)));
    // R5
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> $past(col_valid));
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !col_valid) |=> !win_valid);
endmodule

// File: rtl/avg_window_sum.sv
// Adds the sixteen window values at full precision and divides by the
// window area with a right shift. Assumes the area is a power of two.
module avg_window_sum
    import box_avg_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic [WIN*WIN*DATA_W-1:0] win_data,
    output logic [DATA_W-1:0]         avg
);
    localparam int SUM_W = DATA_W + AREA_SHIFT;

    logic [SUM_W-1:0] acc;

    // Accumulate with enough guard bits that no sum can overflow.
    always_comb begin
        acc = '0;
        for (int i = 0; i < WIN*WIN; i++)
            acc = acc + SUM_W'(win_data[i*DATA_W +: DATA_W]);
    end

    assign avg = acc[SUM_W-1:AREA_SHIFT];
endmodule

// File: rtl/deriv_box_smoother.sv
// 4x4 box averager for one gradient-product stream.
// Chains the row ring, the column window and the adder. A result comes out
// two edges after the input that completes its window. Assumes ROW_LEN >= WIN
// and a raster stream that starts at column 0 of a row after reset.
module deriv_box_smoother
    import box_avg_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int ROW_LEN = 638
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_avg
);
    logic                      col_valid;
    logic                      col_first;
    logic [WIN*DATA_W-1:0]     col_data;
    logic [WIN*WIN*DATA_W-1:0] win_data;

    avg_row_store #(.DATA_W(DATA_W), .ROW_LEN(ROW_LEN)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .col_valid (col_valid),
        .col_first (col_first),
        .col_data  (col_data)
    );

    avg_col_window #(.DATA_W(DATA_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_valid (col_valid),
        .col_first (col_first),
        .col_data  (col_data),
        .win_valid (out_valid),
        .win_data  (win_data)
    );

    avg_window_sum #(.DATA_W(DATA_W)) u_sum (
        .win_data (win_data),
        .avg      (out_avg)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(col_valid));
endmodule

// File: tb/deriv_box_smoother_tb.sv
// Self-checking bench: random data and random idle gaps (with garbage data),
// plus directed full-scale rows and a long idle gap. Expected averages are
// computed from a stored copy of the stimulus image.
module deriv_box_smoother_tb;
    localparam int DATA_W  = 18;
    localparam int ROW_LEN = 10;
    localparam int NROWS   = 9;
    localparam logic [DATA_W-1:0] MAXV = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_avg;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    logic [DATA_W-1:0] img [NROWS][ROW_LEN];
    int                due_q [$];
    bit                exp_q [$];
    logic [DATA_W-1:0] val_q [$];
    string             tag_q [$];

    deriv_box_smoother #(.DATA_W(DATA_W), .ROW_LEN(ROW_LEN)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_avg   (out_avg)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] window_mean(int r, int c);
        logic [DATA_W+3:0] s = '0;
        for (int i = r - 3; i <= r; i++)
            for (int j = c - 3; j <= c; j++)
                s = s + (DATA_W+4)'(img[i][j]);
        return s[DATA_W+3:4];
    endfunction

    function automatic logic [DATA_W-1:0] pick_data(int r);
        if (r >= 4 && r <= 7) return MAXV;   // full-scale rows for R7
        return DATA_W'($urandom);
    endfunction

    function automatic string pick_tag(int r, int c);
        if (r < 3) return "R2";
        if (c < 3) return "R3";
        if (r == 5) return "R6";
        if (r == 6) return "R5";
        if (r == 7) return "R7";
        if (r == 8) return "R8";
        return "R4";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = DATA_W'($urandom);   // garbage must be ignored (R6)
        end
    endtask

    task automatic push_sample(int r, int c);
        @(negedge clk);
        img[r][c] = pick_data(r);
        in_valid  = 1'b1;
        in_data   = img[r][c];
        due_q.push_back(cyc + 2);
        exp_q.push_back(r >= 3 && c >= 3);
        val_q.push_back((r >= 3 && c >= 3) ? window_mean(r, c) : '0);
        tag_q.push_back(pick_tag(r, c));
    endtask

    // Output monitor: compares each due slot and flags stray strobes.
    always @(negedge clk) begin
        if (running) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                if (exp_q[0]) begin
                    check(out_valid == 1'b1, tag_q[0], "strobe missing", int'(out_valid), 1);
                    check(out_avg == val_q[0], tag_q[0], "average", int'(out_avg), int'(val_q[0]));
                end else begin
                    check(out_valid == 1'b0, tag_q[0], "output before window full", int'(out_valid), 0);
                end
                void'(due_q.pop_front());
                void'(exp_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end else if (out_valid) begin
                check(1'b0, "R5", "stray strobe", 1, 0);
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        repeat (2) @(negedge clk);
        // R1: quiet while in reset
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet on the first cycle after reset
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        running = 1'b1;
        for (int r = 0; r < NROWS; r++) begin
            for (int c = 0; c < ROW_LEN; c++) begin
                if (r == 5 && c == 5) idle(20);          // long gap, R6
                else if (r == 6) idle(0);                // back-to-back, R5
                else idle(int'($urandom_range(0, 2)));
                push_sample(r, c);
            end
        end
        idle(6);
        check(due_q.size() == 0, "R5", "pending results at end", due_q.size(), 0);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule